// File: doc/BRIEF.md
# Control-Hazard Flush Controller

This block decides, every cycle, what happens to the in-flight slots of a five-stage in-order pipeline when a branch outcome or an exception arrives. Fetch keeps going down the sequential path after every branch. When a branch resolves, the block either lets that guess stand at no cost, or kills the wrong-path slots and points fetch at the branch target. A parameter sets the stage where branches resolve. Resolving in decode costs one slot. Resolving in the memory stage costs three.

Exceptions squash the faulting slot and every younger slot. Fetch then goes to a fixed handler address. Older slots keep their right to complete. When both events arrive in the same cycle, the one from the older instruction takes effect. The block also works out which slots still sit behind an unresolved branch. Those slots get no commit permission, so they cannot write registers or memory until their path is confirmed. The logic is purely combinational: every decision applies to the slots present in the same cycle.

Top module: `hz_flush_ctrl`

## Requirements
- R1: With no event, the next-PC select is sequential (code 0), the redirect PC is zero and no flush bit is set.
- R2: A branch that resolves not-taken in the resolution stage causes no flush and keeps the select sequential.
- R3: A taken branch that resolves in resolution stage RES flushes exactly stages 0 to RES-1. That is 1 slot when RES=1 and 3 slots when RES=3. The select is branch (code 1) and the redirect PC equals the target.
- R4: A resolution strobe is ignored when the resolution stage holds no valid instruction.
- R5: A taken exception at stage E flushes stages 0 to E, sets the select to trap (code 2) and drives the handler address.
- R6: When a taken branch and a taken exception coincide, the exception wins if E >= RES. Otherwise the branch wins.
- R7: An exception report is ignored if its stage code is above 4 or its stage holds no valid instruction.
- R8: An exception reported from a speculative slot is ignored.
- R9: Stage s is speculative when some valid branch sits at a stage j with s < j < RES. The commit enable for s is 1 only if s is valid, not flushed and not speculative.
- R10: Stage codes and vector bit positions are IF=0, ID=1, EX=2, MEM=3, WB=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stg_valid | input | 5 | Per-stage occupancy, bit index = stage code |
| stg_is_br | input | 5 | Per-stage flag marking a branch instruction |
| br_done | input | 1 | Branch in the resolution stage resolves this cycle |
| br_taken | input | 1 | Outcome of the resolving branch |
| br_target | input | PC_W | Target address of the resolving branch |
| exc_raise | input | 1 | An exception is reported this cycle |
| exc_stg | input | 3 | Stage code of the faulting instruction |
| npc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 trap |
| npc_value | output | PC_W | Redirect address for the selected source |
| stg_flush | output | 5 | Per-stage kill, turns the slot into a NOP |
| stg_commit_en | output | 5 | Per-stage permission to write state |

## Verification
The hardest case to reach is an exception raised from a slot that is still speculative. It takes a valid branch sitting strictly between the faulting stage and the resolution stage, and that branch must not be resolving yet. The bench builds this case on purpose with a branch in EX and a fault in ID. The same input then gives opposite results in two instances: the MEM-resolving one must ignore the fault, while the ID-resolving one must take it. A long run of random valid, branch and event patterns then hits every priority pairing against the reference model.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int NSTG = 5;
    localparam int STW  = 3;

    typedef logic [NSTG-1:0] stg_vec_t;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_TRAP   = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic     hit;
        stg_vec_t kill;
    } redirect_t;

    // stages strictly below n
    function automatic stg_vec_t below_mask(input int unsigned n);
        stg_vec_t m;
        for (int i = 0; i < NSTG; i++) m[i] = (i < n);
        return m;
    endfunction

    // stages strictly between lo and hi
    function automatic stg_vec_t between_mask(input int unsigned lo, input int unsigned hi);
        stg_vec_t m;
        for (int i = 0; i < NSTG; i++) m[i] = (i > lo) && (i < hi);
        return m;
    endfunction
endpackage

// File: rtl/hz_spec_track.sv
module hz_spec_track
    import hz_pkg::*;
#(
    parameter int RES_STG = 3
) (
    input  stg_vec_t valid,
    input  stg_vec_t is_br,
    output stg_vec_t spec
);
    stg_vec_t live_br;
    assign live_br = valid & is_br;

    // a slot is speculative while an older branch still waits to resolve
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam stg_vec_t WIN = between_mask(s, RES_STG);
        assign spec[s] = |(live_br & WIN);
    end
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
    import hz_pkg::*;
#(
    parameter int RES_STG = 3
) (
    input  stg_vec_t  valid,
    input  logic      done,
    input  logic      taken,
    output redirect_t req
);
    localparam stg_vec_t RES_BIT  = stg_vec_t'(1) << RES_STG;
    localparam stg_vec_t WRONG_PK = below_mask(RES_STG);

    assign req.hit  = done & taken & |(valid & RES_BIT);
    assign req.kill = WRONG_PK;
endmodule

// File: rtl/hz_exc_unit.sv
module hz_exc_unit
    import hz_pkg::*;
(
    input  logic           raise,
    input  logic [STW-1:0] stg_code,
    input  stg_vec_t       valid,
    input  stg_vec_t       spec,
    output redirect_t      req
);
    logic     in_range;
    stg_vec_t onehot;

    assign in_range = stg_code < STW'(NSTG);

    always_comb begin
        for (int i = 0; i < NSTG; i++) begin
            onehot[i]   = in_range && (STW'(i) == stg_code);
            req.kill[i] = in_range && (STW'(i) <= stg_code);
        end
    end

    assign req.hit = raise & |(onehot & valid & ~spec);
endmodule

// File: rtl/hz_flush_ctrl.sv
module hz_flush_ctrl
    import hz_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter int          RES_STG    = 3,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0180
) (
    input  logic [4:0]      stg_valid,
    input  logic [4:0]      stg_is_br,
    input  logic            br_done,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    input  logic            exc_raise,
    input  logic [2:0]      exc_stg,
    output logic [1:0]      npc_sel,
    output logic [PC_W-1:0] npc_value,
    output logic [4:0]      stg_flush,
    output logic [4:0]      stg_commit_en
);
    localparam logic [PC_W-1:0] TRAP_PC = PC_W'(HANDLER_PC);

    stg_vec_t  spec;
    redirect_t br_req, exc_req;
    logic      exc_older, exc_win, br_win;
    npc_sel_e  sel;

    hz_spec_track #(.RES_STG(RES_STG)) u_spec (
        .valid (stg_valid),
        .is_br (stg_is_br),
        .spec  (spec)
    );

    hz_branch_unit #(.RES_STG(RES_STG)) u_br (
        .valid (stg_valid),
        .done  (br_done),
        .taken (br_taken),
        .req   (br_req)
    );

    hz_exc_unit u_exc (
        .raise    (exc_raise),
        .stg_code (exc_stg),
        .valid    (stg_valid),
        .spec     (spec),
        .req      (exc_req)
    );

    // higher stage index = older instruction
    assign exc_older = exc_stg >= STW'(RES_STG);
    assign exc_win   = exc_req.hit & (~br_req.hit | exc_older);
    assign br_win    = br_req.hit & ~exc_win;

    always_comb begin
        sel       = NPC_SEQ;
        npc_value = '0;
        stg_flush = '0;
        if (exc_win) begin
            sel       = NPC_TRAP;
            npc_value = TRAP_PC;
            stg_flush = exc_req.kill;
        end else if (br_win) begin
            sel       = NPC_BRANCH;
            npc_value = br_target;
            stg_flush = br_req.kill;
        end
    end

    assign npc_sel       = sel;
    assign stg_commit_en = stg_valid & ~stg_flush & ~spec;
endmodule

// File: rtl/hz_flush_ctrl_chk.sv
module hz_flush_ctrl_chk #(
    parameter int          PC_W       = 32,
    parameter int          RES_STG    = 3,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0180
) (
    input logic [4:0]      stg_valid,
    input logic [2:0]      exc_stg,
    input logic [PC_W-1:0] br_target,
    input logic [1:0]      npc_sel,
    input logic [PC_W-1:0] npc_value,
    input logic [4:0]      stg_flush,
    input logic [4:0]      stg_commit_en
);
    always_comb begin
        if (!$isunknown({stg_valid, exc_stg, br_target, npc_sel, npc_value,
                         stg_flush, stg_commit_en})) begin
            p_sel_code_r1: assert (npc_sel != 2'd3)
                else $error("illegal next-PC select");
            p_flush_needs_redirect_r1: assert ((stg_flush != '0) == (npc_sel != 2'd0))
                else $error("flush without redirect or redirect without flush");
            p_wrong_path_depth_r3: assert (npc_sel != 2'd1 ||
                                           ($countones(stg_flush) == RES_STG &&
                                            stg_flush[RES_STG] == 1'b0))
                else $error("wrong-path flush depth");
            p_branch_target_r3: assert (npc_sel != 2'd1 || npc_value == br_target)
                else $error("redirect PC is not the target");
            p_trap_depth_r5: assert (npc_sel != 2'd2 ||
                                     ($countones(stg_flush) == int'(exc_stg) + 1 &&
                                      npc_value == PC_W'(HANDLER_PC)))
                else $error("exception flush depth or handler PC");
            p_no_flushed_commit_r9: assert ((stg_commit_en & stg_flush) == '0)
                else $error("flushed slot allowed to commit");
            p_commit_needs_valid_r9: assert ((stg_commit_en & ~stg_valid) == '0)
                else $error("empty slot allowed to commit");
        end
    end
endmodule

bind hz_flush_ctrl hz_flush_ctrl_chk #(
    .PC_W       (PC_W),
    .RES_STG    (RES_STG),
    .HANDLER_PC (HANDLER_PC)
) u_chk (
    .stg_valid     (stg_valid),
    .exc_stg       (exc_stg),
    .br_target     (br_target),
    .npc_sel       (npc_sel),
    .npc_value     (npc_value),
    .stg_flush     (stg_flush),
    .stg_commit_en (stg_commit_en)
);

// File: tb/sim_hz_flush_ctrl.sv
module sim_hz_flush_ctrl;
    localparam logic [31:0] HPC = 32'h0000_0180;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4:0]  v, b;
    logic        bd, bt, er;
    logic [31:0] tgt;
    logic [2:0]  es;

    logic [1:0]  sel0, sel1;
    logic [31:0] val0, val1;
    logic [4:0]  fl0, fl1, ce0, ce1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    hz_flush_ctrl #(.PC_W(32), .RES_STG(3), .HANDLER_PC(HPC)) u0 (
        .stg_valid(v), .stg_is_br(b), .br_done(bd), .br_taken(bt), .br_target(tgt),
        .exc_raise(er), .exc_stg(es), .npc_sel(sel0), .npc_value(val0),
        .stg_flush(fl0), .stg_commit_en(ce0));

    hz_flush_ctrl #(.PC_W(32), .RES_STG(1), .HANDLER_PC(HPC)) u1 (
        .stg_valid(v), .stg_is_br(b), .br_done(bd), .br_taken(bt), .br_target(tgt),
        .exc_raise(er), .exc_stg(es), .npc_sel(sel1), .npc_value(val1),
        .stg_flush(fl1), .stg_commit_en(ce1));

    // behavioural reference built from the requirement text
    task automatic model(input int res, output logic [1:0] xs, output logic [31:0] xv,
                         output logic [4:0] xf, output logic [4:0] xc);
        bit spec [5];
        bit brt, eok, ewin;
        for (int s = 0; s < 5; s++) begin
            spec[s] = 0;
            for (int j = s + 1; j < res; j++)
                if (v[j] && b[j]) spec[s] = 1;
        end
        brt  = bd && bt && v[res];
        eok  = er && (es <= 3'd4) && v[es] && !spec[es];
        ewin = eok && (!brt || int'(es) >= res);
        xs = 2'd0; xv = 32'd0; xf = 5'd0;
        if (ewin) begin
            xs = 2'd2; xv = HPC;
            for (int s = 0; s < 5; s++) xf[s] = (s <= int'(es));
        end else if (brt) begin
            xs = 2'd1; xv = tgt;
            for (int s = 0; s < 5; s++) xf[s] = (s < res);
        end
        for (int s = 0; s < 5; s++) xc[s] = v[s] && !xf[s] && !spec[s];
    endtask

    task automatic cmp(input string tag);
        logic [1:0] xs; logic [31:0] xv; logic [4:0] xf, xc;
        model(3, xs, xv, xf, xc);
        tests++;
        if (sel0 !== xs || val0 !== xv || fl0 !== xf || ce0 !== xc) begin
            fails++;
            $display("FAIL %s u0 act sel=%0d pc=%h fl=%b ce=%b exp sel=%0d pc=%h fl=%b ce=%b",
                     tag, sel0, val0, fl0, ce0, xs, xv, xf, xc);
        end
        model(1, xs, xv, xf, xc);
        tests++;
        if (sel1 !== xs || val1 !== xv || fl1 !== xf || ce1 !== xc) begin
            fails++;
            $display("FAIL %s u1 act sel=%0d pc=%h fl=%b ce=%b exp sel=%0d pc=%h fl=%b ce=%b",
                     tag, sel1, val1, fl1, ce1, xs, xv, xf, xc);
        end
    endtask

    task automatic lit(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] nv, input logic [4:0] nb, input logic nbd,
                         input logic nbt, input logic [31:0] nt, input logic ner,
                         input logic [2:0] nes);
        @(posedge clk);
        #1;
        v = nv; b = nb; bd = nbd; bt = nbt; tgt = nt; er = ner; es = nes;
        @(negedge clk);
    endtask

    initial begin
        v = '0; b = '0; bd = 0; bt = 0; tgt = '0; er = 0; es = '0;

        // R1 R10: quiet pipeline
        apply(5'b11111, 5'b0, 0, 0, 32'h1000, 0, 3'd0);
        cmp("R1");
        lit("R1 sel", 32'(sel0), 32'd0);

        // R2: not-taken outcome
        apply(5'b11111, 5'b01010, 1, 0, 32'h2000, 0, 3'd0);
        cmp("R2");

        // R3: taken branch, squash depth per resolution stage
        apply(5'b11111, 5'b0, 1, 1, 32'h3000, 0, 3'd0);
        cmp("R3");
        lit("R3 u0 slots", 32'($countones(fl0)), 32'd3);
        lit("R3 u1 slots", 32'($countones(fl1)), 32'd1);
        lit("R3 u0 target", val0, 32'h3000);

        // R4: resolution stage empty (ID and MEM both invalid)
        apply(5'b10101, 5'b0, 1, 1, 32'h4000, 0, 3'd0);
        cmp("R4");
        lit("R4 u0 flush", 32'(fl0), 32'd0);

        // R5: exception in EX
        apply(5'b11111, 5'b0, 0, 0, 32'h0, 1, 3'd2);
        cmp("R5");
        lit("R5 u0 flush", 32'(fl0), 32'b00111);

        // R6: fault in WB beats branch; fault in IF loses to branch
        apply(5'b11111, 5'b0, 1, 1, 32'h6000, 1, 3'd4);
        cmp("R6 older fault");
        lit("R6 u0 sel", 32'(sel0), 32'd2);
        apply(5'b11111, 5'b0, 1, 1, 32'h6100, 1, 3'd0);
        cmp("R6 older branch");
        lit("R6 u1 sel", 32'(sel1), 32'd1);
        apply(5'b11111, 5'b0, 1, 1, 32'h6200, 1, 3'd3);
        cmp("R6 same stage");

        // R7: bad stage code, empty faulting stage
        apply(5'b11111, 5'b0, 0, 0, 32'h0, 1, 3'd6);
        cmp("R7 code");
        apply(5'b11011, 5'b0, 0, 0, 32'h0, 1, 3'd2);
        cmp("R7 empty");
        lit("R7 u0 sel", 32'(sel0), 32'd0);

        // R8: fault in ID behind a branch in EX
        apply(5'b11111, 5'b00100, 0, 0, 32'h0, 1, 3'd1);
        cmp("R8");
        lit("R8 u0 ignored", 32'(sel0), 32'd0);
        lit("R8 u1 taken", 32'(sel1), 32'd2);

        // R9: commit gating by speculation
        apply(5'b11111, 5'b00100, 0, 0, 32'h0, 0, 3'd0);
        cmp("R9");
        lit("R9 u0 commit", 32'(ce0), 32'b11100);
        lit("R9 u1 commit", 32'(ce1), 32'b11111);

        // mixed patterns, every cycle against the model
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[4:0], r[9:5], r[10], r[11], {$urandom} & 32'hFFFF_FFFC, r[12], r[15:13]);
            cmp("R1..R9 mix");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule